// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small processor core and decides which of five hardware interrupt lines the core should service next. One line is non-maskable (the trap line), three are maskable lines that each carry a fixed vector (called 7.5, 6.5 and 5.5 after their restart slots), and one is a maskable general request line with no fixed vector. A global enable, written by enable and disable commands, gates every maskable line. A mask-write command sets a separate mask bit for each of the three vectored maskable lines.

The core raises `boundary` for one cycle at each instruction boundary, once the current instruction has completed. On that edge the block samples its candidates and accepts the one with the highest priority. On the following cycle it pulses `irq_req` together with either a 16-bit vector address or, for the general line, an active-low acknowledge strobe that tells external logic to drive an opcode. The block also turns a software restart number into its vector address, and it returns a status byte that shows the pending and mask state.

Top module: `irq_arbiter`

## Requirements
- R1: When several candidates are present at a boundary, the one accepted is the first in this order: trap, 7.5, 6.5, 5.5, general request.
- R2: A vectored acceptance sets `vec_valid` and presents these addresses: trap 16'h0024, 7.5 16'h003C, 6.5 16'h0034, 5.5 16'h002C. A general acceptance leaves `vec_valid` low and `vec_addr` at 0.
- R3: `rst_vec` always equals `rst_num` multiplied by 8, zero-extended to 16 bits. For example, restart 5 gives 16'h0028.
- R4: The trap line ignores the global enable and the masks. It becomes pending only on a clock edge where it is sampled high after being low. It is accepted only if it is still high at the boundary, and a pending trap is dropped if the line falls first. Each rising edge produces at most one acceptance.
- R5: A rising edge on the 7.5 line sets a latch that stays set after the line falls. The latch is cleared by reset, by acceptance of 7.5, and by a mask write with bit 4 set. A new rising edge in the same cycle still sets the latch.
- R6: The 6.5, 5.5 and general lines are level sensitive. Only their level at the boundary edge counts.
- R7: `en_cmd` sets the global enable. `dis_cmd`, reset and acceptance of any maskable line clear it, and each of these wins over `en_cmd` in the same cycle. Acceptance of the trap leaves the enable unchanged.
- R8: Acceptance happens only on an edge where `boundary` is high. `irq_req` is a one-cycle pulse in the cycle after that edge, and the vector outputs are valid during that pulse.
- R9: A mask write with `mask_data[3]`=1 loads `mask_data[2]`, `[1]` and `[0]` as the masks of 7.5, 6.5 and 5.5 (1 = masked). With bit 3 at 0 the masks are unchanged.
- R10: Acceptance of the general line drives `gen_ack_n` low for exactly the one cycle of the `irq_req` pulse.
- R11: `status` reads {0, 7.5 latch, 6.5 level, 5.5 level, global enable, mask 7.5, mask 6.5, mask 5.5}, from bit 7 down to bit 0.
- R12: After reset the global enable is 0, all three masks are 1, no input is pending, `irq_req` is 0 and `gen_ack_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_in | input | 1 | Non-maskable interrupt line |
| s75_in | input | 1 | Edge-latched maskable vectored line |
| lv65_in | input | 1 | Level maskable vectored line |
| lv55_in | input | 1 | Level maskable vectored line |
| gen_in | input | 1 | Level maskable non-vectored line |
| boundary | input | 1 | Instruction boundary strobe from the core |
| en_cmd | input | 1 | Enable command |
| dis_cmd | input | 1 | Disable command |
| mask_wr | input | 1 | Mask-write command strobe |
| mask_data | input | 5 | Mask-write data (bit 4 clears the 7.5 latch, bit 3 enables the mask load, bits 2..0 are the masks) |
| rst_num | input | 3 | Software restart number |
| rst_vec | output | 16 | Restart vector address |
| irq_req | output | 1 | Interrupt accepted, one-cycle pulse |
| vec_valid | output | 1 | `vec_addr` holds a fixed vector |
| vec_addr | output | 16 | Vector address of the accepted line |
| gen_ack_n | output | 1 | Active-low acknowledge for the general line |
| status | output | 8 | Pending and mask status byte |

## Verification
The accept outputs (`irq_req`, `vec_valid`, `vec_addr`, `gen_ack_n`) are due one edge after the boundary edge, so the bench drives each stimulus at a falling edge, lets one rising edge pass, and compares at the next falling edge. Edge detection on the trap and 7.5 lines costs one edge of its own: a rising edge can only be accepted at a boundary one or more cycles later, and the directed cases place the boundary to match. Commands reach the `status` byte one edge after they are issued. The level bits of `status` follow the inputs directly, so they are compared in the same falling-edge sample. `rst_vec` is combinational and is checked a short delay after `rst_num` changes.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trap_in,
  input  logic          s75_in,
  input  logic          lv65_in,
  input  logic          lv55_in,
  input  logic          gen_in,
  input  logic          boundary,
  input  logic          en_cmd,
  input  logic          dis_cmd,
  input  logic          mask_wr,
  input  logic [4:0]    mask_data,
  input  logic [2:0]    rst_num,
  output logic [AW-1:0] rst_vec,
  output logic          irq_req,
  output logic          vec_valid,
  output logic [AW-1:0] vec_addr,
  output logic          gen_ack_n,
  output logic [7:0]    status
);
  localparam logic [AW-1:0] V_TRAP = AW'(16'h0024);
  localparam logic [AW-1:0] V_75   = AW'(16'h003C);
  localparam logic [AW-1:0] V_65   = AW'(16'h0034);
  localparam logic [AW-1:0] V_55   = AW'(16'h002C);

  logic       trap_prev, trap_pend, s75_prev, s75_lat, ie;
  logic [2:0] msk;

  wire trap_rise = trap_in & ~trap_prev;
  wire s75_rise  = s75_in & ~s75_prev;

  wire c_trap = trap_pend & trap_in;
  wire c_75   = ie & ~msk[2] & s75_lat;
  wire c_65   = ie & ~msk[1] & lv65_in;
  wire c_55   = ie & ~msk[0] & lv55_in;
  wire c_gen  = ie & gen_in;

  wire take = boundary & (c_trap | c_75 | c_65 | c_55 | c_gen);

  logic [AW-1:0] pick_vec;
  logic          pick_gen, acc_trap, acc_75;

  always_comb begin
    pick_vec = '0;
    pick_gen = 1'b0;
    acc_trap = 1'b0;
    acc_75   = 1'b0;
    if (c_trap) begin
      pick_vec = V_TRAP;
      acc_trap = take;
    end else if (c_75) begin
      pick_vec = V_75;
      acc_75   = take;
    end else if (c_65) begin
      pick_vec = V_65;
    end else if (c_55) begin
      pick_vec = V_55;
    end else begin
      pick_gen = 1'b1;
    end
  end

  wire acc_mask = take & ~acc_trap;
  wire mw_load  = mask_wr & mask_data[3];
  wire mw_clr75 = mask_wr & mask_data[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_prev <= 1'b0;
      trap_pend <= 1'b0;
      s75_prev  <= 1'b0;
      s75_lat   <= 1'b0;
      ie        <= 1'b0;
      msk       <= 3'b111;
      irq_req   <= 1'b0;
      vec_valid <= 1'b0;
      vec_addr  <= '0;
      gen_ack_n <= 1'b1;
    end else begin
      trap_prev <= trap_in;
      s75_prev  <= s75_in;
      if (!trap_in)      trap_pend <= 1'b0;
      else if (trap_rise) trap_pend <= 1'b1;
      else if (acc_trap)  trap_pend <= 1'b0;
      s75_lat <= s75_rise | (s75_lat & ~mw_clr75 & ~acc_75);
      if (mw_load) msk <= mask_data[2:0];
      if (acc_mask || dis_cmd) ie <= 1'b0;
      else if (en_cmd)         ie <= 1'b1;
      irq_req   <= take;
      vec_valid <= take & ~pick_gen;
      vec_addr  <= (take & ~pick_gen) ? pick_vec : '0;
      gen_ack_n <= ~(take & pick_gen);
    end
  end

  assign status  = {1'b0, s75_lat, lv65_in, lv55_in, ie, msk};
  assign rst_vec = AW'({rst_num, 3'b000});
endmodule

module irq_arbiter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        trap_in,
  input logic        trap_pend,
  input logic        boundary,
  input logic        dis_cmd,
  input logic        mask_wr,
  input logic [4:0]  mask_data,
  input logic        irq_req,
  input logic        vec_valid,
  input logic [15:0] vec_addr,
  input logic        gen_ack_n,
  input logic [7:0]  status
);
  p_trap_forced_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && trap_pend && trap_in) |=> (irq_req && vec_addr == 16'h0024));

  p_ack_shape_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_ack_n |-> (irq_req && !vec_valid && vec_addr == 16'h0000));

  p_boundary_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(boundary));

  p_enable_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && vec_addr != 16'h0024) |-> !status[3]);

  p_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dis_cmd |=> !status[3]);

  p_mask_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && mask_data[3]) |=> status[2:0] == $past(mask_data[2:0]));
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trap_in(trap_in), .trap_pend(trap_pend),
  .boundary(boundary), .dis_cmd(dis_cmd), .mask_wr(mask_wr),
  .mask_data(mask_data), .irq_req(irq_req), .vec_valid(vec_valid),
  .vec_addr(vec_addr), .gen_ack_n(gen_ack_n), .status(status)
);

// File: tb/sim_irq_arbiter.sv
`timescale 1ns/1ps
module sim_irq_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_in = 0, s75_in = 0, lv65_in = 0, lv55_in = 0, gen_in = 0;
  logic boundary = 0, en_cmd = 0, dis_cmd = 0, mask_wr = 0;
  logic [4:0] mask_data = '0;
  logic [2:0] rst_num = '0;
  logic [15:0] rst_vec, vec_addr;
  logic irq_req, vec_valid, gen_ack_n;
  logic [7:0] status;

  int nchk = 0, nerr = 0;

  always #10 clk = ~clk;

  irq_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .trap_in(trap_in), .s75_in(s75_in),
    .lv65_in(lv65_in), .lv55_in(lv55_in), .gen_in(gen_in),
    .boundary(boundary), .en_cmd(en_cmd), .dis_cmd(dis_cmd),
    .mask_wr(mask_wr), .mask_data(mask_data), .rst_num(rst_num),
    .rst_vec(rst_vec), .irq_req(irq_req), .vec_valid(vec_valid),
    .vec_addr(vec_addr), .gen_ack_n(gen_ack_n), .status(status)
  );

  // bench model of the requirements
  logic b_tprev, b_tpend, b_sprev, b_slat, b_ie;
  logic [2:0] b_msk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    b_tprev = 0; b_tpend = 0; b_sprev = 0; b_slat = 0; b_ie = 0; b_msk = 3'b111;
  endtask

  // one clock: predict from current inputs, advance, compare at falling edge
  task automatic cycle(input string tag);
    logic ct, c7, c6, c5, cg, tk, isg, at, a7;
    logic [15:0] v;
    logic e_req, e_vv, e_ackn;
    logic [15:0] e_va;
    ct = b_tpend & trap_in;
    c7 = b_ie & ~b_msk[2] & b_slat;
    c6 = b_ie & ~b_msk[1] & lv65_in;
    c5 = b_ie & ~b_msk[0] & lv55_in;
    cg = b_ie & gen_in;
    tk = boundary & (ct | c7 | c6 | c5 | cg);
    isg = 0; at = 0; a7 = 0;
    if (ct)      begin v = 16'h0024; at = tk; end
    else if (c7) begin v = 16'h003C; a7 = tk; end
    else if (c6) v = 16'h0034;
    else if (c5) v = 16'h002C;
    else begin v = 16'h0000; isg = 1; end
    e_req = tk; e_vv = tk & ~isg; e_va = (tk & ~isg) ? v : 16'h0000; e_ackn = ~(tk & isg);
    if (!trap_in) b_tpend = 0;
    else if (trap_in & ~b_tprev) b_tpend = 1;
    else if (at) b_tpend = 0;
    b_tprev = trap_in;
    b_slat = (s75_in & ~b_sprev) | (b_slat & ~(mask_wr & mask_data[4]) & ~a7);
    b_sprev = s75_in;
    if (mask_wr & mask_data[3]) b_msk = mask_data[2:0];
    if ((tk & ~at) | dis_cmd) b_ie = 0;
    else if (en_cmd) b_ie = 1;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " irq_req"}, 16'(irq_req), 16'(e_req));
    chk({tag, " vec_valid"}, 16'(vec_valid), 16'(e_vv));
    chk({tag, " vec_addr"}, vec_addr, e_va);
    chk({tag, " gen_ack_n"}, 16'(gen_ack_n), 16'(e_ackn));
    chk({tag, " status"}, 16'(status), 16'({1'b0, b_slat, lv65_in, lv55_in, b_ie, b_msk}));
  endtask

  task automatic strobes_off();
    boundary = 0; en_cmd = 0; dis_cmd = 0; mask_wr = 0; mask_data = '0;
  endtask

  task automatic enable_now();
    en_cmd = 1; cycle("R7 enable"); strobes_off();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R12 reset state
    chk("R12 irq_req", 16'(irq_req), 16'h0);
    chk("R12 gen_ack_n", 16'(gen_ack_n), 16'h1);
    chk("R12 status", 16'(status), 16'h0007);

    // R3 restart vectors
    for (int n = 0; n < 8; n++) begin
      rst_num = 3'(n);
      #1;
      chk("R3 rst_vec", rst_vec, 16'(n * 8));
    end
    rst_num = 3'd5; #1;
    chk("R3 restart5", rst_vec, 16'h0028);

    // R4 trap with enable off and masks set
    trap_in = 1; cycle("R4 edge");
    boundary = 1; cycle("R4 accept"); strobes_off();
    chk("R4 trap vector", vec_addr, 16'h0024);
    boundary = 1; cycle("R4 held high"); strobes_off();
    chk("R4 single accept", 16'(irq_req), 16'h0);
    trap_in = 0; cycle("R4 low");
    trap_in = 1; cycle("R4 edge2");
    trap_in = 0; boundary = 1; cycle("R4 dropped"); strobes_off();
    chk("R4 fell before boundary", 16'(irq_req), 16'h0);

    // R7 enable / disable ordering
    en_cmd = 1; dis_cmd = 1; cycle("R7 both"); strobes_off();
    chk("R7 disable wins", 16'(status[3]), 16'h0);
    enable_now();
    chk("R7 enabled", 16'(status[3]), 16'h1);

    // R9 mask writes
    mask_wr = 1; mask_data = 5'b00101; cycle("R9 no load"); strobes_off();
    chk("R9 masks kept", 16'(status[2:0]), 16'h7);
    mask_wr = 1; mask_data = 5'b01000; cycle("R9 load"); strobes_off();
    chk("R9 masks cleared", 16'(status[2:0]), 16'h0);

    // R6 level lines only count at the boundary
    lv65_in = 1; cycle("R6 no boundary");
    chk("R6 no accept", 16'(irq_req), 16'h0);
    chk("R11 level bit", 16'(status[5]), 16'h1);
    lv65_in = 0; boundary = 1; cycle("R6 gone"); strobes_off();
    chk("R6 level gone", 16'(irq_req), 16'h0);

    // R5 edge latch remembered
    s75_in = 1; cycle("R5 rise");
    s75_in = 0; cycle("R5 fall"); cycle("R5 wait");
    chk("R5 latched", 16'(status[6]), 16'h1);
    boundary = 1; cycle("R5 accept"); strobes_off();
    chk("R5 vector", vec_addr, 16'h003C);
    chk("R7 cleared on accept", 16'(status[3]), 16'h0);
    chk("R5 latch cleared", 16'(status[6]), 16'h0);
    s75_in = 1; cycle("R5 rise2"); s75_in = 0;
    mask_wr = 1; mask_data = 5'b10000; cycle("R5 clear"); strobes_off();
    chk("R5 cleared by write", 16'(status[6]), 16'h0);

    // R1 priority ladder
    enable_now();
    lv65_in = 1; lv55_in = 1; gen_in = 1; boundary = 1; cycle("R1 65"); strobes_off();
    chk("R1 65 over 55", vec_addr, 16'h0034);
    chk("R2 vec_valid", 16'(vec_valid), 16'h1);
    enable_now();
    lv65_in = 0; boundary = 1; cycle("R1 55"); strobes_off();
    chk("R1 55 over general", vec_addr, 16'h002C);
    enable_now();
    s75_in = 1; cycle("R1 rise75");
    trap_in = 1; boundary = 1; cycle("R1 75"); strobes_off();
    chk("R1 75 first", vec_addr, 16'h003C);
    enable_now();
    boundary = 1; cycle("R1 trap"); strobes_off();
    chk("R1 trap top", vec_addr, 16'h0024);
    chk("R7 trap keeps enable", 16'(status[3]), 16'h1);
    trap_in = 0; s75_in = 0; lv55_in = 0;

    // R10 general acknowledge
    boundary = 1; cycle("R10 general"); strobes_off();
    chk("R10 ack low", 16'(gen_ack_n), 16'h0);
    chk("R2 general no vector", 16'(vec_valid), 16'h0);
    cycle("R8 pulse end");
    chk("R8 single pulse", 16'(irq_req), 16'h0);
    chk("R10 ack released", 16'(gen_ack_n), 16'h1);
    gen_in = 0;

    // random mix
    for (int i = 0; i < 4000; i++) begin
      boundary  = ($urandom % 4) == 0;
      en_cmd    = ($urandom % 5) == 0;
      dis_cmd   = ($urandom % 12) == 0;
      mask_wr   = ($urandom % 10) == 0;
      mask_data = 5'($urandom);
      if (($urandom % 8) == 0) trap_in = ~trap_in;
      if (($urandom % 3) == 0) s75_in = ~s75_in;
      lv65_in = ($urandom % 3) == 0;
      lv55_in = ($urandom % 3) == 0;
      gen_in  = ($urandom % 3) == 0;
      cycle("R1 R2 R4 R5 R6 R7 R9 R10 R11 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule